// File: doc/BRIEF.md
# Capture Timer

A free-running up-counter with a small register interface and one external capture input. When a chosen transition appears on the capture pin, the running count is copied into a capture register and a single status flag is raised. Software polls that flag in the raw status view (it shows there even when its interrupt is masked), reads the captured value, and re-arms capture by writing one to the flag's bit in the masked status view.

The counter can be started and stopped, preset directly, and either reloaded from a reload register on overflow or run in one-shot fashion. A control bit sets the timer pin direction. A soft reset, requested through a register write, clears the whole block over a fixed number of cycles while a busy bit reports progress.

Writes use `wr_en`, `wr_addr` and `wr_data` and take effect at the clock edge. Reads are combinational from `rd_addr`. The register word addresses are CTRL=0, COUNT=1, RELOAD=2, CAPT=3, RAW=4, MSTAT=5, IEN=6, SYS=7 and IFCFG=8. Any other address reads zero.

Top module: `capture_timer`

## Requirements
- R1: After the active-low hard reset, every register reads zero, `irq` is 0 and `pin_oe` is 1.
- R2: While CTRL bit 0 (run) is 1, COUNT rises by one per clock. While it is 0, COUNT holds. A write to COUNT presets the counter and takes priority over counting.
- R3: With CTRL bit 1 (autoload) set, a running counter at all-ones loads the RELOAD value on the next edge. A RELOAD of zero therefore gives a plain wrapping count.
- R4: With autoload clear, a running counter at all-ones goes to zero and the run bit clears on the same edge, unless CTRL is written in that cycle.
- R5: CTRL bits 3:2 select the capture transition. A value of 1 captures rising edges only. A pin change reaches CAPT and the flag on the third clock edge after the change. CAPT then holds the COUNT value from just before that edge.
- R6: Capture-mode value 2 captures both rising and falling edges and raises the same single flag (RAW bit 0) for either. Values 0 and 3 capture nothing.
- R7: No capture happens unless CTRL bit 4 (pin direction) is 1, meaning input.
- R8: While the flag is set, further edges are ignored, and CAPT and the flag keep their values.
- R9: RAW bit 0 shows the flag whatever IEN bit 0 is. MSTAT bit 0 and the `irq` output both equal the flag AND IEN bit 0.
- R10: Writing 1 to MSTAT bit 0 clears the flag. A write to RAW leaves the flag unchanged.
- R11: Writing 1 to SYS bit 0 starts a soft reset. IFCFG bit 0 then reads 1 for exactly 4 cycles, during which all state reads zero and register writes are ignored. Afterwards every register reads zero.
- R12: `pin_oe` is the inverse of CTRL bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address for writes |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register word address for reads |
| rd_data | output | DW | Read data (combinational) |
| cap_pin | input | 1 | Asynchronous capture input pin |
| pin_oe | output | 1 | Timer pin output enable (1 = driving) |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with an 8-bit counter (DW=8), a 4-cycle soft reset and two synchroniser stages. The narrow counter brings overflow, reload and one-shot stop within a few cycles of a preset. Captured values stay small enough to predict as literals. A behavioural reference model, compared against the outputs on every clock, covers all addresses under edge storms, masked and unmasked flags, and reset during activity.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    localparam int unsigned CTM_A_CTRL   = 0;
    localparam int unsigned CTM_A_COUNT  = 1;
    localparam int unsigned CTM_A_RELOAD = 2;
    localparam int unsigned CTM_A_CAPT   = 3;
    localparam int unsigned CTM_A_RAW    = 4;
    localparam int unsigned CTM_A_MSTAT  = 5;
    localparam int unsigned CTM_A_IEN    = 6;
    localparam int unsigned CTM_A_SYS    = 7;
    localparam int unsigned CTM_A_IFCFG  = 8;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_ANY  = 2'd2,
        EDGE_RSVD = 2'd3
    } ctm_edge_e;

    // bit 4 pin_in, bits 3:2 edge_mode, bit 1 reload_en, bit 0 run
    typedef struct packed {
        logic      pin_in;
        ctm_edge_e edge_mode;
        logic      reload_en;
        logic      run;
    } ctm_ctrl_t;

    localparam int unsigned CTM_CTRL_W = $bits(ctm_ctrl_t);
endpackage

// File: rtl/ctm_edge_det.sv
module ctm_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
            st_d.prev = st_q.sync[MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[MSB] & ~st_q.prev;
    assign fall = ~st_q.sync[MSB] & st_q.prev;

    // R5: a detected transition is reported for one cycle only
    a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !clr) |=> !rise);
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          reload_en,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    input  logic [DW-1:0] rld_val,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    localparam logic [DW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (ld) begin
            st_d.cnt = ld_val;
        end else if (run) begin
            if (st_q.cnt == CNT_MAX) st_d.cnt = reload_en ? rld_val : '0;
            else                     st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = run & ~ld & ~clr & (st_q.cnt == CNT_MAX);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && reload_en) |=> cnt == $past(rld_val));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !reload_en) |=> cnt == '0);
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ctm_pkg::*;
#(
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = 4,
    parameter int unsigned RST_CYCLES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          cap_pin,
    output logic          pin_oe,
    output logic          irq
);
    localparam int unsigned RCW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        ctm_ctrl_t     ctrl;
        logic [DW-1:0] rld;
        logic [DW-1:0] capt;
        logic          flag;
        logic          ien;
        logic [RCW-1:0] rcnt;
    } regs_t;

    regs_t q, d;

    logic          busy, sys_wr, blk_clr;
    logic          we_ctrl, we_count, we_rld, we_mstat, we_ien;
    logic          rise, fall, qual, take;
    logic [DW-1:0] cnt;
    logic          cnt_wrap;

    function automatic logic addr_is(input logic [AW-1:0] a, input int unsigned idx);
        return a == AW'(idx);
    endfunction

    assign busy     = (q.rcnt != '0);
    assign we_ctrl  = wr_en && !busy && addr_is(wr_addr, CTM_A_CTRL);
    assign we_count = wr_en && !busy && addr_is(wr_addr, CTM_A_COUNT);
    assign we_rld   = wr_en && !busy && addr_is(wr_addr, CTM_A_RELOAD);
    assign we_mstat = wr_en && !busy && addr_is(wr_addr, CTM_A_MSTAT);
    assign we_ien   = wr_en && !busy && addr_is(wr_addr, CTM_A_IEN);
    assign sys_wr   = wr_en && !busy && addr_is(wr_addr, CTM_A_SYS) && wr_data[0];
    assign blk_clr  = busy || sys_wr;

    ctm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (blk_clr),
        .pin  (cap_pin),
        .rise (rise),
        .fall (fall)
    );

    ctm_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (blk_clr),
        .run      (q.ctrl.run),
        .reload_en(q.ctrl.reload_en),
        .ld       (we_count),
        .ld_val   (wr_data),
        .rld_val  (q.rld),
        .cnt      (cnt),
        .wrap     (cnt_wrap)
    );

    always_comb begin
        unique case (q.ctrl.edge_mode)
            EDGE_RISE: qual = rise;
            EDGE_ANY:  qual = rise | fall;
            default:   qual = 1'b0;
        endcase
        qual = qual & q.ctrl.pin_in;
        take = qual & ~q.flag;
    end

    always_comb begin
        d = q;
        if (busy) begin
            d      = '0;
            d.rcnt = q.rcnt - 1'b1;
        end else if (sys_wr) begin
            d      = '0;
            d.rcnt = RCW'(RST_CYCLES);
        end else begin
            if (take) begin
                d.capt = cnt;
                d.flag = 1'b1;
            end else if (we_mstat && wr_data[0]) begin
                d.flag = 1'b0;
            end
            if (we_ctrl)                                d.ctrl = ctm_ctrl_t'(wr_data[CTM_CTRL_W-1:0]);
            else if (cnt_wrap && !q.ctrl.reload_en)     d.ctrl.run = 1'b0;
            if (we_rld) d.rld = wr_data;
            if (we_ien) d.ien = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(CTM_A_CTRL):   rd_data[CTM_CTRL_W-1:0] = q.ctrl;
            AW'(CTM_A_COUNT):  rd_data = cnt;
            AW'(CTM_A_RELOAD): rd_data = q.rld;
            AW'(CTM_A_CAPT):   rd_data = q.capt;
            AW'(CTM_A_RAW):    rd_data[0] = q.flag;
            AW'(CTM_A_MSTAT):  rd_data[0] = q.flag & q.ien;
            AW'(CTM_A_IEN):    rd_data[0] = q.ien;
            AW'(CTM_A_IFCFG):  rd_data[0] = busy;
            default:           rd_data = '0;
        endcase
    end

    assign irq    = q.flag & q.ien;
    assign pin_oe = ~q.ctrl.pin_in;

    a_r8_capt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !(we_mstat && wr_data[0]) && !blk_clr) |=> ($stable(q.capt) && q.flag));

    a_r10_raw_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && wr_en && addr_is(wr_addr, CTM_A_RAW) && !busy) |=> q.flag);

    a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.ctrl == '0 && !q.flag && cnt == '0 && !irq));

    a_r7_input_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $past(q.ctrl.pin_in));

    a_r4_run_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wrap && !q.ctrl.reload_en && !we_ctrl) |=> !q.ctrl.run);
endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int RSTC = 4;
    localparam int MAXV = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          cap_pin = 1'b0;
    logic          pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    capture_timer #(.DW(DW), .AW(AW), .RST_CYCLES(RSTC), .SYNC_STAGES(2)) i_capture_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_cnt, m_rld, m_capt, m_rst, m_mode;
    bit m_run, m_rel, m_pin_in, m_flag, m_ien;
    bit m_pin [$];

    task automatic m_zero();
        m_cnt = 0; m_rld = 0; m_capt = 0; m_mode = 0;
        m_run = 0; m_rel = 0; m_pin_in = 0; m_flag = 0; m_ien = 0;
        m_pin = '{0, 0, 0};
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_zero();
            m_rst = 0;
        end else if (m_rst > 0) begin
            m_zero();
            m_rst = m_rst - 1;
        end else if (wr_en && wr_addr == 7 && wr_data[0]) begin
            m_zero();
            m_rst = RSTC;
        end else begin
            bit seen_now, seen_old, up, dn, hit, take;
            int old_cnt;
            bit old_run, old_rel;
            seen_now = m_pin[1];
            seen_old = m_pin[2];
            up = seen_now && !seen_old;
            dn = !seen_now && seen_old;
            hit = m_pin_in && ((m_mode == 1 && up) || (m_mode == 2 && (up || dn)));
            take = hit && !m_flag;
            old_cnt = m_cnt; old_run = m_run; old_rel = m_rel;
            if (take) begin m_capt = old_cnt; m_flag = 1; end
            else if (wr_en && wr_addr == 5 && wr_data[0]) m_flag = 0;
            if (wr_en && wr_addr == 1) m_cnt = int'(wr_data);
            else if (old_run) m_cnt = (old_cnt == MAXV) ? (old_rel ? m_rld : 0) : old_cnt + 1;
            if (wr_en && wr_addr == 0) begin
                m_run = wr_data[0]; m_rel = wr_data[1];
                m_mode = int'(wr_data[3:2]); m_pin_in = wr_data[4];
            end else if (old_run && !(wr_en && wr_addr == 1) && old_cnt == MAXV && !old_rel) begin
                m_run = 0;
            end
            if (wr_en && wr_addr == 2) m_rld = int'(wr_data);
            if (wr_en && wr_addr == 6) m_ien = wr_data[0];
            m_pin.push_front(cap_pin);
            void'(m_pin.pop_back());
        end
    end

    function automatic int exp_rd(int a);
        case (a)
            0: return (int'(m_pin_in) << 4) | (m_mode << 2) | (int'(m_rel) << 1) | int'(m_run);
            1: return m_cnt;
            2: return m_rld;
            3: return m_capt;
            4: return int'(m_flag);
            5: return int'(m_flag && m_ien);
            6: return int'(m_ien);
            8: return int'(m_rst > 0);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R4";
            1: return "R2";
            2: return "R3";
            3: return "R5";
            4, 6: return "R9";
            5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(int'(rd_addr)), int'(rd_data), exp_rd(int'(rd_addr)));
            chk("R9", int'(irq), int'(m_flag && m_ien));
            chk("R12", int'(pin_oe), int'(!m_pin_in));
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(int a, int v);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(v);
        tick();
        wr_en = 0;
    endtask

    task automatic peek(int a, string tag, int exp);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        for (int a = 0; a < 9; a++) peek(a, "R1", 0);
        @(negedge clk);
        chk("R1", int'(irq), 0);
        chk("R1", int'(pin_oe), 1);
        tick();

        // R2 preset, hold, count
        wr(1, 8'h10);
        peek(1, "R2", 8'h10);
        tick(3);
        peek(1, "R2", 8'h10);
        rd_addr = 1;
        wr(0, 8'h01);
        tick(2);
        peek(1, "R2", 8'h12);

        // R3 autoload
        wr(0, 0); wr(2, 8'h20); wr(1, 8'hFE);
        wr(0, 8'h03);
        tick(3);
        peek(1, "R3", 8'h21);
        wr(0, 0); wr(2, 0); wr(1, 8'hFF);
        wr(0, 8'h03);
        peek(1, "R3", 8'hFF);
        peek(1, "R3", 8'h00);

        // R4 one-shot
        wr(0, 0); wr(1, 8'hFE);
        wr(0, 8'h01);
        tick(4);
        peek(0, "R4", 0);
        peek(1, "R4", 0);

        // R5 rising capture, R12 direction
        wr(0, 8'h15);
        @(negedge clk); chk("R12", int'(pin_oe), 0); tick();
        wr(1, 0);
        cap_pin = 1;
        tick(4);
        peek(3, "R5", 2);
        peek(4, "R5", 1);

        // R8 hold while flag set
        cap_pin = 0; tick(3); cap_pin = 1; tick(4);
        peek(3, "R8", 2);
        peek(4, "R8", 1);

        // R9 masking
        peek(5, "R9", 0);
        @(negedge clk); chk("R9", int'(irq), 0); tick();
        wr(6, 1);
        @(negedge clk); chk("R9", int'(irq), 1); tick();
        peek(5, "R9", 1);
        peek(4, "R9", 1);

        // R10 clear path
        wr(4, 1);
        peek(4, "R10", 1);
        wr(5, 1);
        peek(4, "R10", 0);
        @(negedge clk); chk("R10", int'(irq), 0); tick();

        // R5 falling edge ignored in rise mode
        cap_pin = 0; tick(5);
        peek(4, "R5", 0);

        // R6 both edges
        wr(0, 8'h19);
        cap_pin = 1; tick(5);
        peek(4, "R6", 1);
        wr(5, 1);
        wr(1, 8'h40);
        cap_pin = 0; tick(4);
        peek(4, "R6", 1);
        peek(3, "R6", 8'h42);
        wr(5, 1);
        wr(0, 8'h1D);
        cap_pin = 1; tick(5); cap_pin = 0; tick(5);
        peek(4, "R6", 0);
        wr(0, 8'h11);
        cap_pin = 1; tick(5); cap_pin = 0; tick(5);
        peek(4, "R6", 0);

        // R7 pin as output blocks capture
        wr(0, 8'h05);
        @(negedge clk); chk("R12", int'(pin_oe), 1); tick();
        cap_pin = 1; tick(5); cap_pin = 0; tick(5);
        peek(4, "R7", 0);

        // R11 soft reset
        wr(0, 8'h15); wr(2, 8'h33); wr(6, 1);
        cap_pin = 1; tick(5);
        rd_addr = 8;
        wr(7, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R11", int'(rd_data), (i < 4) ? 1 : 0);
            @(posedge clk); #2;
        end
        for (int a = 0; a < 9; a++) peek(a, "R11", 0);
        wr(7, 1);
        wr(0, 8'h03);
        wr(2, 8'h55);
        tick(5);
        peek(0, "R11", 0);
        peek(2, "R11", 0);
        peek(1, "R11", 0);

        // free run across a full wrap under model comparison
        rd_addr = 1;
        wr(0, 8'h03);
        tick(300);
        peek(1, "R3", exp_rd(1));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule